// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and calendar date as a chain of packed-BCD registers. A fast enable pulse (`base_tick`) feeds a prescaler, which produces one advance per `PRESCALE` pulses, nominally once per second. Each advance ripples through seconds, minutes, hours, day-of-week, date, month and two-digit year. The ripple accounts for month lengths, for leap years, and for both the 12-hour and the 24-hour hour formats.

A host sees the seven fields as byte registers at addresses 0 to 6. It loads any field through a one-cycle write port and reads any register image through a combinational read port. Bit 7 of the seconds register is a halt flag: while it is set, the prescaler and the whole chain stand still. Writing the seconds register restarts the sub-second phase, so time set by the host begins exactly one full second later.

Top module: `caltime_core`

## Requirements
- R1: After reset the registers read: seconds 0x00 (halt clear), minutes 0x00, hours 0x00 (24-hour mode), day 0x01, date 0x01, month 0x01, year 0x00.
- R2: Seconds (address 0, bits 6:0) and minutes (address 1) count 0x00 to 0x59 in BCD. Rolling from 0x59 to 0x00 advances the next field by one.
- R3: While bit 7 of the seconds register is 1, no field changes and the prescaler holds its count, however many `base_tick` pulses arrive. Clearing the bit resumes counting.
- R4: With hours bit 6 = 0 (24-hour), hours count 0x00 to 0x23. The step from 0x23 to 0x00 advances day-of-week and date.
- R5: With hours bit 6 = 1 (12-hour), bit 5 is PM and bits 4:0 hold BCD 01 to 12. The sequence runs 12 AM (0x52), 01 AM (0x41) to 11 AM (0x51), then 12 PM (0x72), 01 PM (0x61) to 11 PM (0x71). Only the step from 11 PM to 12 AM advances day-of-week and date.
- R6: Day-of-week (address 3) counts 1 to 7, and a day advance from 7 gives 1.
- R7: Date (address 4) wraps to 0x01 and advances the month after the last day of the month. The last day is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. For February it is 29 when the two-digit year (address 6) is a multiple of 4, 00 included, and 28 otherwise.
- R8: Month (address 5) counts 0x01 to 0x12, and the wrap to 0x01 advances the year. The year counts 0x00 to 0x99 and wraps to 0x00.
- R9: A write to address 0 to 6 loads that field in the next cycle. Bits outside the field are dropped and read as 0: minutes 7 bits, hours 7 bits, day 3 bits, date 6 bits, month 5 bits, seconds and year 8 bits. Address 7 reads 0x00.
- R10: The chain advances once per `PRESCALE` accepted `base_tick` pulses. A write to address 0 restarts that count, so the next advance follows a full `PRESCALE` pulses later.
- R11: A whole carry chain, from seconds through year, completes in the single cycle that takes the advance. A host write in that same cycle replaces only its own field; the other fields still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | Sub-second enable pulse fed to the prescaler |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write register address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Host read register address |
| rd_data | output | 8 | Register image at `rd_addr` (combinational) |

## Verification
The bench builds the block with `PRESCALE` = 4, so one second costs four clocks. At that rate a full hour can be swept second by second, ending in a rollover of every field from the last second of year 99. Every hour step of both formats is walked, and the last two days of every month are run for leap, non-leap, 00 and 99 years. The small prescaler also makes it cheap to check its restart, the halt hold, and a write that lands in the same cycle as an advance.

// File: rtl/caltime_pkg.sv
package caltime_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  // packed BCD increment of a two-digit value (no range wrap)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // two-digit BCD year: leap when binary value is a multiple of 4
  function automatic logic is_leap(input logic [7:0] y);
    logic [7:0] b;
    b = 8'(y[7:4]) * 8'd10 + 8'(y[3:0]);
    return (b[1:0] == 2'b00);
  endfunction

  // last date (BCD) of a BCD month
  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // next hour image, result {day_carry, hour[6:0]}
  function automatic logic [7:0] hour_step(input logic [6:0] h);
    logic       pm;
    logic [4:0] v12;
    logic [5:0] v24;
    if (h[6]) begin
      pm  = h[5];
      v12 = h[4:0];
      if (v12 == 5'h12)      return {1'b0, 1'b1, pm, 5'h01};
      else if (v12 == 5'h11) return {pm, 1'b1, ~pm, 5'h12};
      else                   return {1'b0, 1'b1, pm, 5'(bcd_inc({3'b0, v12}))};
    end else begin
      v24 = h[5:0];
      if (v24 == 6'h23) return {1'b1, 1'b0, 6'h00};
      else              return {1'b0, 1'b0, 6'(bcd_inc({2'b0, v24}))};
    end
  endfunction
endpackage

// File: rtl/caltime_prescale.sv
module caltime_prescale #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_tick,
  input  logic freeze,
  input  logic restart,
  output logic sec_tick
);
  localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept   = base_tick && !freeze;
  assign sec_tick = accept && (cnt == LAST) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (accept)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // R10
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R3
  pre_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !restart) |=> $stable(cnt));
endmodule

// File: rtl/caltime_clock.sv
module caltime_clock
  import caltime_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [7:0]        sec_q,
  output logic [6:0]        min_q,
  output logic [6:0]        hr_q,
  output logic              halt,
  output logic              day_carry
);
  logic       wr_sec, wr_min, wr_hr;
  logic       sec_wrap, min_wrap;
  logic [7:0] hstep;

  assign wr_sec    = wr_en && (wr_addr == ADDR_W'(0));
  assign wr_min    = wr_en && (wr_addr == ADDR_W'(1));
  assign wr_hr     = wr_en && (wr_addr == ADDR_W'(2));
  assign halt      = sec_q[7];
  assign sec_wrap  = adv && (sec_q[6:0] == 7'h59);
  assign min_wrap  = sec_wrap && (min_q == 7'h59);
  assign hstep     = hour_step(hr_q);
  assign day_carry = min_wrap && hstep[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 8'h00;
      min_q <= 7'h00;
      hr_q  <= 7'h00;
    end else begin
      if (wr_sec)   sec_q <= wr_data;
      else if (adv) sec_q <= {sec_q[7], sec_wrap ? 7'h00 : 7'(bcd_inc({1'b0, sec_q[6:0]}))};
      if (wr_min)        min_q <= wr_data[6:0];
      else if (sec_wrap) min_q <= min_wrap ? 7'h00 : 7'(bcd_inc({1'b0, min_q}));
      if (wr_hr)         hr_q <= wr_data[6:0];
      else if (min_wrap) hr_q <= hstep[6:0];
    end
  end

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wrap && !wr_sec) |=> (sec_q[6:0] == 7'h00));
  // R4
  day_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && !wr_hr) |=> (hr_q == 7'h00 || hr_q == 7'h52));
  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q)));
endmodule

// File: rtl/caltime_calendar.sv
module caltime_calendar
  import caltime_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_carry,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [2:0]        day_q,
  output logic [5:0]        date_q,
  output logic [4:0]        mon_q,
  output logic [7:0]        yr_q
);
  logic wr_day, wr_date, wr_mon, wr_yr;
  logic date_wrap, mon_wrap;

  assign wr_day    = wr_en && (wr_addr == ADDR_W'(3));
  assign wr_date   = wr_en && (wr_addr == ADDR_W'(4));
  assign wr_mon    = wr_en && (wr_addr == ADDR_W'(5));
  assign wr_yr     = wr_en && (wr_addr == ADDR_W'(6));
  assign date_wrap = day_carry && ({2'b0, date_q} == last_date({3'b0, mon_q}, yr_q));
  assign mon_wrap  = date_wrap && (mon_q == 5'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day_q  <= 3'd1;
      date_q <= 6'h01;
      mon_q  <= 5'h01;
      yr_q   <= 8'h00;
    end else begin
      if (wr_day)         day_q <= wr_data[2:0];
      else if (day_carry) day_q <= (day_q == 3'd7) ? 3'd1 : day_q + 3'd1;
      if (wr_date)        date_q <= wr_data[5:0];
      else if (day_carry) date_q <= date_wrap ? 6'h01 : 6'(bcd_inc({2'b0, date_q}));
      if (wr_mon)         mon_q <= wr_data[4:0];
      else if (date_wrap) mon_q <= mon_wrap ? 5'h01 : 5'(bcd_inc({3'b0, mon_q}));
      if (wr_yr)          yr_q <= wr_data;
      else if (mon_wrap)  yr_q <= (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);
    end
  end

  // R6
  day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && day_q == 3'd7 && !wr_day) |=> (day_q == 3'd1));
  // R7
  date_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (date_wrap && !wr_date) |=> (date_q == 6'h01));
  // R8
  year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_wrap && yr_q == 8'h99 && !wr_yr) |=> (yr_q == 8'h00));
endmodule

// File: rtl/caltime_core.sv
module caltime_core
  import caltime_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic       sec_tick, halt, day_carry, sec_restart;
  logic [7:0] sec_q, yr_q;
  logic [6:0] min_q, hr_q;
  logic [2:0] day_q;
  logic [5:0] date_q;
  logic [4:0] mon_q;

  assign sec_restart = wr_en && (wr_addr == ADDR_W'(0));

  caltime_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .freeze(halt),
    .restart(sec_restart), .sec_tick(sec_tick));

  caltime_clock u_clk (
    .clk(clk), .rst_n(rst_n), .adv(sec_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q), .halt(halt),
    .day_carry(day_carry));

  caltime_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .day_carry(day_carry), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .day_q(day_q), .date_q(date_q), .mon_q(mon_q), .yr_q(yr_q));

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = sec_q;
      3'd1:    rd_data = {1'b0, min_q};
      3'd2:    rd_data = {1'b0, hr_q};
      3'd3:    rd_data = {5'b0, day_q};
      3'd4:    rd_data = {2'b0, date_q};
      3'd5:    rd_data = {3'b0, mon_q};
      3'd6:    rd_data = yr_q;
      default: rd_data = 8'h00;
    endcase
  end

  // R3
  halt_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !sec_tick);
  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && wr_en && wr_addr == 3'd1) |=> (min_q == $past(wr_data[6:0])));
endmodule

// File: tb/sim_caltime_core.sv
module sim_caltime_core;
  localparam int CLK_NS = 10;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  caltime_core #(.PRESCALE(P)) u0 (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] img12(int h);
    int h12;
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | to_bcd(h12);
  endfunction

  function automatic int month_len(int m, int y);
    int lens[12] = '{31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31};
    if (m == 2 && (y % 4) == 0) return 29;
    return lens[m-1];
  endfunction

  task automatic drive(input logic bt, input logic we, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    base_tick = bt; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    base_tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    drive(1'b0, 1'b1, a, d);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] got;
    rd(a, got);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s addr=%0d actual=0x%02h expected=0x%02h", req, a, got, exp);
    end
  endtask

  task automatic set_all(input logic [7:0] yr, mo, dt, dy, hr, mi, se);
    wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, dy);
    wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset images
    chk("R1", 3'd0, 8'h00); chk("R1", 3'd1, 8'h00); chk("R1", 3'd2, 8'h00);
    chk("R1", 3'd3, 8'h01); chk("R1", 3'd4, 8'h01); chk("R1", 3'd5, 8'h01);
    chk("R1", 3'd6, 8'h00);

    // R9 field masks and unused address
    wr(3'd1, 8'hFF); chk("R9", 3'd1, 8'h7F);
    wr(3'd2, 8'hFF); chk("R9", 3'd2, 8'h7F);
    wr(3'd3, 8'hFF); chk("R9", 3'd3, 8'h07);
    wr(3'd4, 8'hFF); chk("R9", 3'd4, 8'h3F);
    wr(3'd5, 8'hFF); chk("R9", 3'd5, 8'h1F);
    wr(3'd6, 8'hA5); chk("R9", 3'd6, 8'hA5);
    wr(3'd7, 8'hAA); chk("R9", 3'd7, 8'h00);

    // R2 R11 hour sweep ending in a full rollover out of year 99
    set_all(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h00, 8'h00);
    for (int s = 1; s <= 3600; s++) begin
      pulses(P);
      chk("R2", 3'd0, to_bcd(s % 60));
      chk("R2", 3'd1, to_bcd((s / 60) % 60));
      if (s < 3600) chk("R4", 3'd2, 8'h23);
    end
    chk("R11", 3'd2, 8'h00); chk("R11", 3'd3, 8'h06); chk("R11", 3'd4, 8'h01);
    chk("R11", 3'd5, 8'h01); chk("R8", 3'd6, 8'h00);

    // R4 every 24-hour step
    for (int h = 0; h < 24; h++) begin
      set_all(8'h21, 8'h06, 8'h10, 8'h02, to_bcd(h), 8'h59, 8'h59);
      pulses(P);
      chk("R4", 3'd2, to_bcd((h + 1) % 24));
      chk("R4", 3'd3, (h == 23) ? 8'h03 : 8'h02);
      chk("R4", 3'd4, (h == 23) ? 8'h11 : 8'h10);
    end

    // R5 every 12-hour step
    for (int h = 0; h < 24; h++) begin
      set_all(8'h21, 8'h06, 8'h10, 8'h02, img12(h), 8'h59, 8'h59);
      pulses(P);
      chk("R5", 3'd2, img12((h + 1) % 24));
      chk("R5", 3'd3, (h == 23) ? 8'h03 : 8'h02);
    end
    chk("R5", 3'd0, 8'h00);

    // R6 R7 R8 month ends for several years
    for (int yi = 0; yi < 7; yi++) begin
      int yrs[7] = '{0, 1, 2, 3, 4, 96, 99};
      int y;
      y = yrs[yi];
      for (int m = 1; m <= 12; m++) begin
        int last;
        last = month_len(m, y);
        set_all(to_bcd(y), to_bcd(m), to_bcd(last - 1), 8'h07, 8'h23, 8'h59, 8'h59);
        pulses(P);
        chk("R7", 3'd4, to_bcd(last));
        chk("R6", 3'd3, 8'h01);
        chk("R7", 3'd5, to_bcd(m));
        set_all(to_bcd(y), to_bcd(m), to_bcd(last), 8'h03, 8'h23, 8'h59, 8'h59);
        pulses(P);
        chk("R7", 3'd4, 8'h01);
        chk("R6", 3'd3, 8'h04);
        chk("R8", 3'd5, to_bcd((m == 12) ? 1 : m + 1));
        chk("R8", 3'd6, to_bcd((m == 12) ? (y + 1) % 100 : y));
      end
    end

    // R3 halt holds everything
    set_all(8'h10, 8'h03, 8'h05, 8'h01, 8'h08, 8'h20, 8'hB0);
    pulses(5 * P);
    chk("R3", 3'd0, 8'hB0);
    chk("R3", 3'd1, 8'h20);
    wr(3'd0, 8'h30);
    pulses(P);
    chk("R3", 3'd0, 8'h31);

    // R10 seconds write restarts the prescaler
    wr(3'd0, 8'h10);
    pulses(P - 1);
    wr(3'd0, 8'h20);
    pulses(P - 1);
    chk("R10", 3'd0, 8'h20);
    pulses(1);
    chk("R10", 3'd0, 8'h21);

    // R11 write coinciding with an advance
    wr(3'd1, 8'h05);
    wr(3'd0, 8'h59);
    pulses(P - 1);
    drive(1'b1, 1'b1, 3'd1, 8'h10);
    chk("R11", 3'd0, 8'h00);
    chk("R11", 3'd1, 8'h10);
    chk("R11", 3'd2, 8'h08);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule